// File: doc/BRIEF.md
# Decision-Tree Channel Lookup Walker

This block turns a 12-bit peripheral identity into an 8-bit channel number by walking a binary decision tree held in an on-block table of 255 words of 32 bits. The identity is formed from a 4-bit slave number in the upper bits and an 8-bit peripheral number in the lower bits. Every table word names one identity bit to test, and for each outcome of that test it carries a flag and an 8-bit field. The flag says whether the field is the index of the next word to visit or the final channel number.

Software or a boot sequencer fills the table through a simple write port. A requester then raises a one-cycle request while the walker is idle. The walker reads one table word per clock, starting at word 0. It finishes with a one-cycle done pulse that carries either a channel number or a not-found flag. A walk ends as not-found when it runs out of depth or when a branch points outside the table.

Top module: `tree_walker`

## Requirements
- R1: While reset is held and on the first cycle after it, busy, done, found and notFound are all low.
- R2: A request is taken only on a clock edge where reqValid is high and busy is low. A request raised while busy is high is ignored: it changes neither the result of the walk in progress nor produces a second done.
- R3: The identity is {slaveId, periphNum}. Selector value s tests identity bit s, so selector 0 tests periphNum[0] and selector 8 tests slaveId[0].
- R4: In a table word, bits [21:18] are the selector. If the tested bit is 1, bit 8 is the flag and bits [7:0] are the field. If the tested bit is 0, bit 17 is the flag and bits [16:9] are the field.
- R5: Every walk starts at word 0. A flag of 1 makes the field the next word index. A flag of 0 ends the walk with found high and channel equal to the field.
- R6: The walker reads one word per clock. When a request is taken at edge E and the walk reads N words, done is high for the cycle after edge E+N.
- R7: If the 16th word read still has its flag set, the walk ends not-found after exactly 16 reads. A result reached on the 16th read is still found.
- R8: A branch whose next index is 255 or above ends the walk not-found at that read.
- R9: Selector values 12 to 15 test a bit that reads as 0.
- R10: done is a single-cycle pulse. found and notFound are high only with done, and exactly one of them is high then. channel holds the result when found and 0 when not-found.
- R11: wrEn writes wrData into word wrAddr at the clock edge. A walk reading that same word in the cycle of the write decides on the old content; later reads see the new content.
- R12: busy is low in the done cycle, so a new request raised then is taken at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | 8 | Table word index for a write |
| wrData | input | 32 | Table word to write |
| reqValid | input | 1 | Lookup request, taken only while idle |
| slaveId | input | 4 | Upper part of the identity |
| periphNum | input | 8 | Lower part of the identity |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Walk ended with a channel |
| notFound | output | 1 | Walk ended without a channel |
| channel | output | 8 | Channel number, valid with done and found |

## Verification
A table write and a walk read can land on the same word in the same cycle. The bench raises wrEn for the word at a known tree level in exactly the cycle in which the walk reads that word, counting the cycles from the edge that took the request. It then expects the walk to finish with the channel from the old content. A second lookup over the same path must return the new channel, which shows that the write took effect at that edge and was neither lost nor seen early.

// File: rtl/tree_walker_pkg.sv
package tree_walker_pkg;

  // table word layout; the walker decodes these fixed positions
  localparam int SEL_LSB    = 18;
  localparam int SEL_W      = 4;
  localparam int ZERO_FLAG  = 17;
  localparam int ZERO_LSB   = 9;
  localparam int ONE_FLAG   = 8;
  localparam int ONE_LSB    = 0;
  localparam int FIELD_W    = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walkState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;
    logic advance;
    logic finishHit;
    logic finishMiss;
  } walkStrobes_t;

endpackage

// File: rtl/walk_table.sv
module walk_table #(
  parameter int ENTRIES = 255,
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 8
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [WORD_W-1:0] rdData
);

  logic [WORD_W-1:0] mem [ENTRIES];

  logic wrInRange;
  logic rdInRange;
  assign wrInRange = 32'(wrAddr) < ENTRIES;
  assign rdInRange = 32'(rdAddr) < ENTRIES;

  always_ff @(posedge clk) begin
    if (wrEn && wrInRange) begin
      mem[wrAddr] <= wrData;
    end
  end

  // asynchronous read: a write at this edge is seen only from the next cycle
  assign rdData = rdInRange ? mem[rdAddr] : '0;

endmodule

// File: rtl/walk_datapath.sv
module walk_datapath
  import tree_walker_pkg::*;
#(
  parameter int ENTRIES   = 255,
  parameter int WORD_W    = 32,
  parameter int IDX_W     = 8,
  parameter int SLAVE_W   = 4,
  parameter int PERIPH_W  = 8,
  parameter int MAX_STEPS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  walkStrobes_t        strobe,
  input  logic [SLAVE_W-1:0]  slaveId,
  input  logic [PERIPH_W-1:0] periphNum,
  input  logic [WORD_W-1:0]   rdData,
  output logic [IDX_W-1:0]    rdAddr,
  output logic                contFlag,
  output logic                badNext,
  output logic                lastStep,
  output logic [IDX_W-1:0]    channel
);

  localparam int ID_W   = SLAVE_W + PERIPH_W;
  localparam int STEP_W = $clog2(MAX_STEPS + 1);

  logic [ID_W-1:0]   idReg;
  logic [IDX_W-1:0]  indexReg;
  logic [STEP_W-1:0] stepCnt;
  logic [IDX_W-1:0]  channelReg;

  logic [SEL_W-1:0]   sel;
  logic               testBit;
  logic [FIELD_W-1:0] field;
  logic               unusedHigh;

  assign sel        = rdData[SEL_LSB +: SEL_W];
  assign unusedHigh = ^rdData[WORD_W-1:SEL_LSB+SEL_W];

  // selectors past the identity width read as zero
  always_comb begin
    testBit = 1'b0;
    for (int b = 0; b < ID_W; b++) begin
      if (32'(sel) == b) testBit = idReg[b];
    end
  end

  assign contFlag = testBit ? rdData[ONE_FLAG] : rdData[ZERO_FLAG];
  assign field    = testBit ? rdData[ONE_LSB +: FIELD_W] : rdData[ZERO_LSB +: FIELD_W];
  assign badNext  = contFlag && (32'(field) >= ENTRIES);
  assign lastStep = (stepCnt == STEP_W'(MAX_STEPS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg      <= '0;
      indexReg   <= '0;
      stepCnt    <= '0;
      channelReg <= '0;
    end else if (strobe.load) begin
      idReg      <= {slaveId, periphNum};
      indexReg   <= '0;
      stepCnt    <= '0;
      channelReg <= '0;
    end else if (strobe.advance) begin
      indexReg <= IDX_W'(field);
      stepCnt  <= stepCnt + 1'b1;
    end else if (strobe.finishHit) begin
      channelReg <= IDX_W'(field);
    end else if (strobe.finishMiss) begin
      channelReg <= '0;
    end
  end

  assign rdAddr  = indexReg;
  assign channel = channelReg;

  // R7: control never steps past the last permitted read
  assert_no_step_past_limit_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> !lastStep);

  // R8: a followed branch always lands inside the table
  assert_index_in_table_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (32'(indexReg) < ENTRIES));

  // R5: a fresh walk begins at word 0
  assert_walk_starts_at_root_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (indexReg == '0) && (stepCnt == '0));

endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import tree_walker_pkg::*;
#(
  parameter int MAX_STEPS = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         contFlag,
  input  logic         badNext,
  input  logic         lastStep,
  output walkStrobes_t strobe,
  output logic         busy,
  output logic         done,
  output logic         found,
  output logic         notFound
);

  localparam int RUN_W = $clog2(MAX_STEPS + 2);

  walkState_t state;

  always_comb begin
    strobe = '0;
    if (state == ST_IDLE) begin
      strobe.load = reqValid;
    end else begin
      strobe.finishHit  = !contFlag;
      strobe.finishMiss = contFlag && (badNext || lastStep);
      strobe.advance    = contFlag && !badNext && !lastStep;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      found    <= 1'b0;
      notFound <= 1'b0;
    end else begin
      done     <= strobe.finishHit || strobe.finishMiss;
      found    <= strobe.finishHit;
      notFound <= strobe.finishMiss;
      if (strobe.load) begin
        state <= ST_WALK;
      end else if (strobe.finishHit || strobe.finishMiss) begin
        state <= ST_IDLE;
      end
    end
  end

  assign busy = (state == ST_WALK);

  // checker counter: length of the current walk in cycles
  logic [RUN_W-1:0] walkLen;
  always_ff @(posedge clk) begin
    if (!rstN || !busy) walkLen <= '0;
    else                walkLen <= walkLen + 1'b1;
  end

  assert_walk_bounded_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (32'(walkLen) < MAX_STEPS));

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($countones({found, notFound}) == 1));

  assert_flags_only_with_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (!found && !notFound));

  assert_done_single_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_request_taken_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  assert_done_follows_walk_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  assert_idle_at_done_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/tree_walker.sv
module tree_walker
  import tree_walker_pkg::*;
#(
  parameter int ENTRIES   = 255,
  parameter int WORD_W    = 32,
  parameter int IDX_W     = 8,
  parameter int SLAVE_W   = 4,
  parameter int PERIPH_W  = 8,
  parameter int MAX_STEPS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrAddr,
  input  logic [WORD_W-1:0]   wrData,
  input  logic                reqValid,
  input  logic [SLAVE_W-1:0]  slaveId,
  input  logic [PERIPH_W-1:0] periphNum,
  output logic                busy,
  output logic                done,
  output logic                found,
  output logic                notFound,
  output logic [IDX_W-1:0]    channel
);

  walkStrobes_t      strobe;
  logic [IDX_W-1:0]  rdAddr;
  logic [WORD_W-1:0] rdData;
  logic              contFlag;
  logic              badNext;
  logic              lastStep;

  walk_table #(
    .ENTRIES(ENTRIES), .WORD_W(WORD_W), .IDX_W(IDX_W)
  ) u_table (
    .clk(clk), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  walk_datapath #(
    .ENTRIES(ENTRIES), .WORD_W(WORD_W), .IDX_W(IDX_W),
    .SLAVE_W(SLAVE_W), .PERIPH_W(PERIPH_W), .MAX_STEPS(MAX_STEPS)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .slaveId(slaveId), .periphNum(periphNum), .rdData(rdData),
    .rdAddr(rdAddr), .contFlag(contFlag), .badNext(badNext),
    .lastStep(lastStep), .channel(channel)
  );

  walk_ctrl #(
    .MAX_STEPS(MAX_STEPS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .contFlag(contFlag), .badNext(badNext), .lastStep(lastStep),
    .strobe(strobe), .busy(busy), .done(done),
    .found(found), .notFound(notFound)
  );

endmodule

// File: tb/sim_tree_walker.sv
module sim_tree_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        reqValid = 1'b0;
  logic [3:0]  slaveId = '0;
  logic [7:0]  periphNum = '0;
  logic        busy, done, found, notFound;
  logic [7:0]  channel;

  int checks = 0;
  int fails  = 0;

  logic [31:0] shadow [255];

  always #5 clk = ~clk;

  tree_walker u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .reqValid(reqValid), .slaveId(slaveId), .periphNum(periphNum),
    .busy(busy), .done(done), .found(found), .notFound(notFound),
    .channel(channel)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int sel, input bit c0, input int f0,
                                     input bit c1, input int f1);
    return (32'(sel) << 18) | (32'(c0) << 17) | (32'(f0 & 8'hFF) << 9) |
           (32'(c1) << 8) | 32'(f1 & 8'hFF);
  endfunction

  // reference walk derived from R3-R9
  function automatic void model(input logic [11:0] id, output bit hit,
                                output int ch, output int reads);
    int idx = 0;
    hit = 0; ch = 0; reads = 0;
    for (int s = 0; s < 16; s++) begin
      logic [31:0] e;
      int sel;
      bit b, c;
      int f;
      e = shadow[idx];
      reads++;
      sel = int'(e[21:18]);
      b = (sel < 12) ? id[sel] : 1'b0;
      c = b ? e[8] : e[17];
      f = b ? int'(e[7:0]) : int'(e[16:9]);
      if (!c) begin hit = 1; ch = f; return; end
      if (f >= 255) return;
      idx = f;
    end
  endfunction

  task automatic writeEntry(input int addr, input logic [31:0] data);
    wrEn = 1'b1; wrAddr = 8'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    if (addr < 255) shadow[addr] = data;
  endtask

  // starts and ends on a negedge; injKind 1 = extra request, 2 = table write
  task automatic runLookup(input logic [3:0] sid, input logic [7:0] per, input string tag,
                           input int injAt = 0, input int injKind = 0,
                           input int injAddr = 0, input logic [31:0] injData = '0);
    bit hit; int ch; int reads; int n;
    model({sid, per}, hit, ch, reads);
    reqValid = 1'b1; slaveId = sid; periphNum = per;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    n = 1;
    while (1) begin
      if (n == injAt && injKind == 1) begin
        reqValid = 1'b1; slaveId = ~sid; periphNum = ~per;
      end
      if (n == injAt && injKind == 2) begin
        wrEn = 1'b1; wrAddr = 8'(injAddr); wrData = injData;
      end
      if (done || n >= 40) break;
      @(negedge clk);
      reqValid = 1'b0; wrEn = 1'b0;
      n++;
    end
    check(done == 1'b1, {tag, " R6 done seen"}, int'(done), 1);
    check(n == reads + 1, {tag, " R6 latency"}, n, reads + 1);
    check(found == hit, {tag, " R10 found"}, int'(found), int'(hit));
    check(notFound == !hit, {tag, " R10 notFound"}, int'(notFound), int'(!hit));
    check(int'(channel) == ch, {tag, " R5 channel"}, int'(channel), ch);
    check(busy == 1'b0, {tag, " R12 idle at done"}, int'(busy), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic testReset();
    repeat (3) @(negedge clk);
    check({busy, done, found, notFound} == 4'b0, "R1 in reset", int'({busy, done, found, notFound}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, done, found, notFound} == 4'b0, "R1 after reset", int'({busy, done, found, notFound}), 0);
  endtask

  task automatic testRootLeaf();
    writeEntry(0, mk(0, 0, 8'h11, 0, 8'h22));
    runLookup(4'h0, 8'h01, "R4 root tested one");
    runLookup(4'h0, 8'h00, "R4 root tested zero");
  endtask

  task automatic testMultiLevel();
    writeEntry(0, mk(8, 1, 3, 1, 5));
    writeEntry(3, mk(4, 0, 8'h33, 0, 8'h34));
    writeEntry(5, mk(11, 1, 7, 0, 8'hA5));
    writeEntry(7, mk(2, 0, 8'h70, 0, 8'h71));
    runLookup(4'h1, 8'h00, "R3 slave bit0 to level3");
    runLookup(4'h9, 8'h00, "R3 slave bit3 leaf");
    runLookup(4'h1, 8'h04, "R3 periph bit2");
    runLookup(4'h0, 8'h10, "R3 periph bit4");
    runLookup(4'h0, 8'hEF, "R3 periph bit4 clear");
  endtask

  task automatic testDepth();
    writeEntry(0, mk(0, 1, 20, 1, 20));
    for (int j = 0; j < 14; j++) writeEntry(20 + j, mk(j % 12, 1, 21 + j, 1, 21 + j));
    writeEntry(34, mk(0, 0, 8'h5A, 0, 8'h5B));
    runLookup(4'h3, 8'h21, "R7 hit on 16th read");
    writeEntry(34, mk(0, 1, 35, 1, 35));
    writeEntry(35, mk(0, 0, 8'h66, 0, 8'h67));
    runLookup(4'h3, 8'h21, "R7 depth exhausted");
  endtask

  task automatic testBadIndex();
    writeEntry(0, mk(3, 1, 255, 1, 254));
    writeEntry(254, mk(0, 0, 8'hE0, 0, 8'hE1));
    runLookup(4'h0, 8'h00, "R8 index 255");
    runLookup(4'h0, 8'h08, "R8 index 254 valid");
  endtask

  task automatic testHighSelector();
    writeEntry(0, mk(13, 0, 8'h0C, 0, 8'h0D));
    runLookup(4'hF, 8'hFF, "R9 selector 13");
    writeEntry(0, mk(11, 0, 8'h0B, 0, 8'hB0));
    runLookup(4'h8, 8'h00, "R9 selector 11 boundary");
  endtask

  task automatic testBusyIgnore();
    writeEntry(0, mk(0, 1, 20, 1, 20));
    writeEntry(34, mk(0, 0, 8'h5A, 0, 8'h5B));
    runLookup(4'h2, 8'h00, "R2 request while busy", 4, 1);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R2 no second walk", int'({busy, done}), 0);
    end
  endtask

  task automatic testWriteCollision();
    writeEntry(0, mk(0, 1, 1, 1, 1));
    writeEntry(1, mk(0, 0, 8'h10, 0, 8'h11));
    // second read (word 1) happens in the cycle whose negedge is n=2
    runLookup(4'h0, 8'h00, "R11 collision old value", 2, 2, 1, mk(0, 0, 8'h99, 0, 8'h98));
    shadow[1] = mk(0, 0, 8'h99, 0, 8'h98);
    runLookup(4'h0, 8'h00, "R11 new value seen");
  endtask

  initial begin : main
    for (int a = 0; a < 255; a++) shadow[a] = '0;
    testReset();
    for (int a = 0; a < 255; a++) writeEntry(a, 32'h0);
    testRootLeaf();
    testMultiLevel();
    testDepth();
    testBadIndex();
    testHighSelector();
    testBusyIgnore();
    testWriteCollision();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule